// File: doc/BRIEF.md
# Scheduled Tile Crossbar Switch

This block is the data switch sitting in one tile of a mesh of processing tiles. It has five ports: the four mesh neighbours (north, south, east and west) and the tile's own core. Each port has an input and an output. A crossbar joins every input to every output.

The crossbar is not set by packet headers or by a request and grant scheme. A small instruction memory holds a routing schedule that is worked out ahead of time. A program counter steps through it once per clock, so every transfer lands in a known cycle. One input can feed several outputs in the same cycle.

Each output goes through one register before it leaves the tile, which makes each hop a single pipeline stage. The schedule is written through a configuration port while the switch is stopped. It then plays in a loop of programmable length while the run enable is high.

Top module: `tile_xbar_switch`

## Requirements
- R1: While reset is asserted (rstN low) and in the first cycle after it, every outValid bit and all of outData are zero.
- R2: The instruction word holds one 4-bit field per output port: the field for output port p is at bits [4p+3:4p]. Bit 3 of the field enables the output and bits 2:0 pick the source: 0 north, 1 south, 2 east, 3 west, 4 core. Port p occupies inData/outData bits [16p+15:16p] and bit p of inValid/outValid. When the field is enabled and names a source 0 to 4, that output carries the source's data and valid bit.
- R3: Several outputs may name the same source in one instruction word. All of them then carry that source's data and valid bit in the same cycle.
- R4: An output whose field has bit 3 clear, or whose select is 5, 6 or 7, drives all-zero data with its valid bit low.
- R5: Each output is registered once. The value seen after a clock edge comes from the inputs and the instruction that were present before that edge.
- R6: While runEn is high, the program counter advances by one each cycle. After entry schedLen-1 it returns to entry 0. schedLen may be 1 to 32, and a length of 1 repeats entry 0.
- R7: While runEn is low, the program counter is held at entry 0 and the outputs are zero with valid low. When runEn rises, the schedule starts again from entry 0.
- R8: A write (cfgWe high) stores cfgData at entry cfgAddr only while runEn is low. A write made while runEn is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Schedule playback enable |
| cfgWe | input | 1 | Instruction memory write strobe |
| cfgAddr | input | 5 | Instruction memory write address |
| cfgData | input | 20 | Instruction word to store |
| schedLen | input | 6 | Number of schedule entries, 1 to 32 |
| inData | input | 80 | Input data, 16 bits per port, port p at [16p+15:16p] |
| inValid | input | 5 | Input valid, one bit per port |
| outData | output | 80 | Registered output data, same packing as inData |
| outValid | output | 5 | Registered output valid, one bit per port |

## Verification
Two things can happen in the same cycle: the schedule wraps back to entry 0, and a configuration write aimed at entry 0 arrives while runEn is still high. The bench issues that write in the middle of a running pass. On the following pass it checks that entry 0 still fans north out to south and east, which shows the write was dropped.

A second collision is runEn falling partway through the schedule. The bench checks that the outputs go idle in the very next cycle, and that the first cycle after runEn rises again plays entry 0 rather than the entry where playback stopped.

// File: rtl/tile_xbar_pkg.sv
package tile_xbar_pkg;
  localparam int NPORT   = 5;
  localparam int SELW    = 3;
  localparam int FLDW    = SELW + 1;
  localparam int INSTR_W = NPORT * FLDW;

  typedef enum logic [SELW-1:0] {
    SRC_NORTH = 3'd0,
    SRC_SOUTH = 3'd1,
    SRC_EAST  = 3'd2,
    SRC_WEST  = 3'd3,
    SRC_CORE  = 3'd4
  } srcSel_e;

  // strobes handed from the scheduler to the datapath
  typedef struct packed {
    logic               drive;
    logic [INSTR_W-1:0] instr;
  } xbarCtl_t;
endpackage

// File: rtl/tile_sched_ctrl.sv
module tile_sched_ctrl
  import tile_xbar_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PCW   = $clog2(DEPTH),
  parameter int LENW  = PCW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                cfgWe,
  input  logic [PCW-1:0]      cfgAddr,
  input  logic [INSTR_W-1:0]  cfgData,
  input  logic [LENW-1:0]     schedLen,
  output xbarCtl_t            ctl,
  output logic [PCW-1:0]      pcVal
);
  logic [INSTR_W-1:0] instrMem [DEPTH];
  logic [PCW-1:0]     pc;
  logic [LENW-1:0]    pcNextWide;
  logic               atLast;

  // loader: writes only while playback is stopped (R8)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) instrMem[i] <= '0;
    end else if (cfgWe && !runEn) begin
      instrMem[cfgAddr] <= cfgData;
    end
  end

  assign pcNextWide = {1'b0, pc} + LENW'(1);
  assign atLast     = (pcNextWide >= schedLen);

  // program counter: held at zero while stopped, wraps at schedLen (R6, R7)
  always_ff @(posedge clk) begin
    if (!rstN || !runEn) pc <= '0;
    else if (atLast)     pc <= '0;
    else                 pc <= pc + PCW'(1);
  end

  assign ctl.drive = runEn;
  assign ctl.instr = instrMem[pc];
  assign pcVal     = pc;
endmodule

// File: rtl/tile_xbar_datapath.sv
module tile_xbar_datapath
  import tile_xbar_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  xbarCtl_t            ctl,
  input  logic [NPORT*DW-1:0] inData,
  input  logic [NPORT-1:0]    inValid,
  output logic [NPORT*DW-1:0] outData,
  output logic [NPORT-1:0]    outValid
);
  logic [DW-1:0] inArr [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_unpack
    assign inArr[p] = inData[p*DW +: DW];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [FLDW-1:0] fld;
    logic [SELW-1:0] sel;
    logic            useIt;
    logic [DW-1:0]   nextData;
    logic            nextValid;

    assign fld   = ctl.instr[o*FLDW +: FLDW];
    assign sel   = fld[SELW-1:0];
    assign useIt = ctl.drive && fld[FLDW-1] && (sel < SELW'(NPORT));

    always_comb begin
      nextData  = '0;
      nextValid = 1'b0;
      if (useIt) begin
        nextData  = inArr[sel];
        nextValid = inValid[sel];
      end
    end

    // one pipeline register per output (R5)
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outData[o*DW +: DW] <= '0;
        outValid[o]         <= 1'b0;
      end else begin
        outData[o*DW +: DW] <= nextData;
        outValid[o]         <= nextValid;
      end
    end
  end
endmodule

// File: rtl/tile_xbar_switch.sv
module tile_xbar_switch
  import tile_xbar_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int PCW   = $clog2(DEPTH),
  parameter int LENW  = PCW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                cfgWe,
  input  logic [PCW-1:0]      cfgAddr,
  input  logic [INSTR_W-1:0]  cfgData,
  input  logic [LENW-1:0]     schedLen,
  input  logic [NPORT*DW-1:0] inData,
  input  logic [NPORT-1:0]    inValid,
  output logic [NPORT*DW-1:0] outData,
  output logic [NPORT-1:0]    outValid
);
  xbarCtl_t       ctl;
  logic [PCW-1:0] pcVal;

  tile_sched_ctrl #(.DEPTH(DEPTH), .PCW(PCW), .LENW(LENW)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .schedLen(schedLen),
    .ctl(ctl), .pcVal(pcVal)
  );

  tile_xbar_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .inValid(inValid), .outData(outData), .outValid(outValid)
  );
endmodule

// File: rtl/tile_xbar_switch_chk.sv
module tile_xbar_switch_chk
  import tile_xbar_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PCW  = 5,
  parameter int LENW = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                runEn,
  input logic [LENW-1:0]     schedLen,
  input logic [NPORT-1:0]    inValid,
  input logic [NPORT*DW-1:0] outData,
  input logic [NPORT-1:0]    outValid,
  input logic [PCW-1:0]      pcVal
);
  // R7: stopped cycle yields idle outputs
  a_r7_stopped_idle: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (outValid == '0 && outData == '0));

  // R7: counter parked at entry 0 while stopped
  a_r7_pc_parked: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (pcVal == '0));

  // R6: step by one before the last entry
  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && (({1'b0, pcVal} + LENW'(1)) < schedLen)) |=> (pcVal == $past(pcVal) + PCW'(1)));

  // R6: wrap after the last entry
  a_r6_pc_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && (({1'b0, pcVal} + LENW'(1)) >= schedLen)) |=> (pcVal == '0));

  // R5: a valid output needs a valid input one cycle earlier
  a_r5_valid_source: assert property (@(posedge clk) disable iff (!rstN)
    (outValid != '0) |-> ($past(inValid) != '0));
endmodule

bind tile_xbar_switch tile_xbar_switch_chk #(.DW(DW), .PCW(PCW), .LENW(LENW)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .schedLen(schedLen),
  .inValid(inValid), .outData(outData), .outValid(outValid), .pcVal(pcVal)
);

// File: tb/tb_tile_xbar_switch.sv
`timescale 1ns/1ps
module tb_tile_xbar_switch;
  localparam int NP = 5;
  localparam int DW = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           runEn = 1'b0;
  logic           cfgWe = 1'b0;
  logic [4:0]     cfgAddr = '0;
  logic [19:0]    cfgData = '0;
  logic [5:0]     schedLen = 6'd1;
  logic [79:0]    inData = '0;
  logic [4:0]     inValid = '0;
  logic [79:0]    outData;
  logic [4:0]     outValid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  logic [19:0] img [32];

  always #2.5 clk = ~clk;

  tile_xbar_switch dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .schedLen(schedLen), .inData(inData), .inValid(inValid),
    .outData(outData), .outValid(outValid)
  );

  function automatic logic [3:0] fld(input bit en, input int src);
    return {en, 3'(src)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic calcExp(input logic [19:0] ins, input logic [79:0] d, input logic [4:0] v,
                         output logic [79:0] ed, output logic [4:0] ev);
    ed = '0; ev = '0;
    for (int o = 0; o < NP; o++) begin
      logic [3:0] f;
      f = ins[4*o +: 4];
      if (f[3] && f[2:0] < 3'd5) begin
        ed[16*o +: 16] = d[16*f[2:0] +: 16];
        ev[o] = v[f[2:0]];
      end
    end
  endtask

  task automatic loadEntry(input int a, input logic [19:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 5'(a); cfgData = w;
    img[a] = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic driveStim();
    for (int p = 0; p < NP; p++) inData[16*p +: 16] = 16'(cyc * 37 + p * 1111 + 1);
    inValid = 5'(cyc * 7 + 3) | 5'b00001;
    if (cyc % 4 == 3) inValid[0] = 1'b0;
    cyc++;
  endtask

  // assumes we stand at a negedge; checks the output after one edge
  task automatic stepCheck(input logic [19:0] ins, input string req);
    logic [79:0] d, ed;
    logic [4:0]  v, ev;
    driveStim();
    d = inData; v = inValid;
    @(negedge clk);
    calcExp(ins, d, v, ed, ev);
    check(outData == ed, req, outData, ed);
    check(outValid == ev, req, {75'd0, outValid}, {75'd0, ev});
  endtask

  task automatic stepIdle(input string req);
    driveStim();
    @(negedge clk);
    check(outData == '0 && outValid == '0, req, outData, '0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outData == '0 && outValid == '0, "R1 reset", outData, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(outData == '0 && outValid == '0, "R1 after reset", outData, '0);
  endtask

  task automatic testMixedSchedule();
    // entry 0: north fans out to south and east (R3)
    loadEntry(0, {fld(0,0), fld(0,0), fld(1,0), fld(1,0), fld(0,0)});
    // entry 1: core->north, west->core, south select 5 enabled (R4)
    loadEntry(1, {fld(1,3), fld(0,2), fld(0,1), fld(1,5), fld(1,4)});
    // entry 2: all from east
    loadEntry(2, {fld(1,2), fld(1,2), fld(1,2), fld(1,2), fld(1,2)});
    // entry 3: identity
    loadEntry(3, {fld(1,4), fld(1,3), fld(1,2), fld(1,1), fld(1,0)});
    schedLen = 6'd4;
    @(negedge clk);
    runEn = 1'b1;
    stepCheck(img[0], "R3 fanout entry0");
    stepCheck(img[1], "R4 idle select");
    // write attempt while running, aimed at entry 0 (R8)
    cfgWe = 1'b1; cfgAddr = 5'd0; cfgData = '0;
    stepCheck(img[2], "R2 all from east");
    cfgWe = 1'b0;
    stepCheck(img[3], "R5 identity latency");
    stepCheck(img[0], "R6 wrap and R8 write ignored");
    stepCheck(img[1], "R6 second pass");
    // stop partway (R7)
    runEn = 1'b0;
    stepIdle("R7 stopped outputs idle");
    stepIdle("R7 still idle");
    runEn = 1'b1;
    stepCheck(img[0], "R7 restart from entry0");
    stepCheck(img[1], "R7 continues entry1");
    runEn = 1'b0;
    stepIdle("R7 idle");
  endtask

  task automatic testLenOne();
    schedLen = 6'd1;
    runEn = 1'b1;
    for (int k = 0; k < 3; k++) stepCheck(img[0], "R6 length one");
    runEn = 1'b0;
    stepIdle("R7 idle");
  endtask

  task automatic testFull();
    for (int k = 0; k < 32; k++)
      loadEntry(k, {fld(1,(k+1)%5), fld(k%2==0,6), fld(1,4), fld(k%2==0,k%5), fld(1,k%5)});
    schedLen = 6'd32;
    runEn = 1'b1;
    for (int k = 0; k < 34; k++) stepCheck(img[k%32], "R6 full length");
    runEn = 1'b0;
    stepIdle("R7 idle");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) img[i] = '0;
    testReset();
    testMixedSchedule();
    testLenOne();
    testFull();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule